// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer with Power Control

This block is the digital core of a 12-bit, 8-input successive-approximation converter. The bus front end decodes a command and gives it three fields: a single-ended/differential flag, a 3-bit channel code and a 2-bit power mode. When the channel part of a write command has been received, the front end pulses `start_i`. The block then latches the channel and drives one-hot positive and negative mux selects. It powers the reference, the core and the search clock, and it resolves one result bit per clock, most significant bit first. Each bit is decided by a comparator that sits outside the block, along with the capacitor DAC. The finished 12-bit straight-binary code goes into a holding register. A one-cycle `done_o` strobe marks the update.

The sequencer has four states: `ST_IDLE`, `ST_SAMPLE`, `ST_CONVERT` and `ST_DONE`. The transitions are:

- **accept**: `ST_IDLE` to `ST_SAMPLE`, when `start_i` is high.
- **acquire**: `ST_SAMPLE` to `ST_CONVERT`, unconditional.
- **resolve**: `ST_CONVERT` to `ST_CONVERT`, while more bits remain.
- **finish**: `ST_CONVERT` to `ST_DONE`, when the last bit is latched.
- **release**: `ST_DONE` to `ST_IDLE`, unconditional.

Once the block is idle again, the stored power mode decides which of the reference and the core stay powered. The search clock enable is off whenever the sequencer is idle.

Top module: `sar_conv_ctrl`

## Requirements
- R1: After reset, `busy_o`, `done_o`, `clk_en_o`, `ref_en_o` and `core_en_o` are 0, `result_o` is 0, and no bit of `pos_sel_o` or `neg_sel_o` is set.
- R2: A `start_i` sampled high in `ST_IDLE` raises `busy_o` on the next cycle. `busy_o` stays high for 13 cycles. `done_o` is high for exactly one cycle, 14 cycles after the start edge, with `busy_o` low.
- R3: The search is MSB first. In the first resolve cycle `dac_code_o` is 12'h800. Each trial code is the bits decided so far plus the current trial bit. A bit is kept when `cmp_i` is 1, which means the selected input is at or above `dac_code_o`. For an ideal comparator the result equals the input difference in LSBs, clamped to 0..4095.
- R4: With `se_i` = 1, `neg_sel_o[8]` (the common pin) is the negative input. The positive input is selected by `chan_i`: codes 0 to 3 pick inputs 0, 2, 4 and 6, and codes 4 to 7 pick inputs 1, 3, 5 and 7.
- R5: With `se_i` = 0, codes 0 to 3 select the pairs (0,1), (2,3), (4,5) and (6,7), with the even input positive. Codes 4 to 7 select the same pairs with the odd input positive.
- R6: While `busy_o` or `done_o` is high, `clk_en_o`, `ref_en_o` and `core_en_o` are all 1.
- R7: `pwr_i` is sampled on the edge that latches the last bit. Once the block is back in `ST_IDLE`, `ref_en_o` equals bit 1 of that sample, `core_en_o` equals bit 0, and `clk_en_o` is 0. The value 00 powers both down.
- R8: A `start_i` outside `ST_IDLE` is ignored. The channel selects, the cycle count and the result all follow the accepted command.
- R9: `result_o` changes only on the edge that also raises `done_o`, and it holds across idle time regardless of `cmp_i`.
- R10: The mux selects keep the latched channel after the conversion until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Channel field of a write command received |
| se_i | input | 1 | 1 = single-ended against common, 0 = differential pair |
| chan_i | input | 3 | Channel code |
| pwr_i | input | 2 | Power mode: bit 1 keeps the reference on, bit 0 keeps the core on |
| cmp_i | input | 1 | Comparator decision: input at or above trial code |
| dac_code_o | output | 12 | Trial code to the capacitor DAC |
| pos_sel_o | output | 8 | One-hot positive mux select |
| neg_sel_o | output | 9 | One-hot negative mux select, bit 8 is the common pin |
| clk_en_o | output | 1 | Search clock run enable |
| ref_en_o | output | 1 | Reference enable |
| core_en_o | output | 1 | Converter core enable |
| busy_o | output | 1 | Sample and resolve in progress |
| done_o | output | 1 | One-cycle result strobe |
| result_o | output | 12 | Held straight-binary result |

## Verification
Some behaviours are checked by assertions on every cycle:

- the one-cycle width of `done_o`, and that it follows the fall of `busy_o`;
- all three enables being on while the sequencer is active;
- one-hot selects, and that they do not move when a start arrives outside `ST_IDLE`;
- that the result register changes only with the strobe;
- the single-step descent of the bit pointer.

Other behaviours only the bench scenarios can show, because they need an analog model. These are that the search converges to the right code, including the clamp at zero for negative differences and the full-scale code. The bench also checks the exact select mapping for every code in both input modes, and the enable levels left behind by each power mode.

// File: rtl/sar_ctrl_pkg.sv
package sar_ctrl_pkg;
    localparam int SAR_NUM_IN = 8;
    localparam int SAR_CH_W   = $clog2(SAR_NUM_IN);

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_SAMPLE  = 2'd1,
        ST_CONVERT = 2'd2,
        ST_DONE    = 2'd3
    } sar_state_t;
endpackage

// File: rtl/sar_seq_fsm.sv
module sar_seq_fsm
    import sar_ctrl_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic       last_bit_i,
    output sar_state_t state_o,
    output logic       load_o,
    output logic       step_o,
    output logic       finish_o
);
    sar_state_t state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (start_i) state_d = ST_SAMPLE;
            ST_SAMPLE:  state_d = ST_CONVERT;
            ST_CONVERT: if (last_bit_i) state_d = ST_DONE;
            ST_DONE:    state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        load_o   = 1'b0;
        step_o   = 1'b0;
        finish_o = 1'b0;
        unique case (state_q)
            ST_IDLE:    load_o = start_i;
            ST_SAMPLE:  ;
            ST_CONVERT: begin
                step_o   = 1'b1;
                finish_o = last_bit_i;
            end
            ST_DONE:    ;
        endcase
    end

    assign state_o = state_q;

    // R2: one acquire cycle precedes the resolve phase
    a_r2_sample_then_convert: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_SAMPLE |=> state_q == ST_CONVERT);
    // R2: the done state lasts one cycle
    a_r2_done_then_idle: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_DONE |=> state_q == ST_IDLE);
endmodule

// File: rtl/sar_search_reg.sv
module sar_search_reg #(
    parameter int RES_BITS = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                init_i,
    input  logic                step_i,
    input  logic                cmp_i,
    output logic [RES_BITS-1:0] trial_o,
    output logic [RES_BITS-1:0] code_next_o,
    output logic                last_o
);
    localparam int PTR_W = $clog2(RES_BITS);
    localparam logic [PTR_W-1:0] TOP_PTR = PTR_W'(RES_BITS - 1);

    logic [RES_BITS-1:0] sar_q;
    logic [PTR_W-1:0]    ptr_q;
    logic [RES_BITS-1:0] trial_bit;

    assign trial_bit   = {{(RES_BITS-1){1'b0}}, 1'b1} << ptr_q;
    assign trial_o     = sar_q | trial_bit;
    assign code_next_o = cmp_i ? trial_o : sar_q;
    assign last_o      = (ptr_q == '0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sar_q <= '0;
            ptr_q <= TOP_PTR;
        end else if (init_i) begin
            sar_q <= '0;
            ptr_q <= TOP_PTR;
        end else if (step_i) begin
            sar_q <= code_next_o;
            if (!last_o) ptr_q <= ptr_q - 1'b1;
        end
    end

    // R3: the pointer walks down one position per resolve step
    a_r3_ptr_descends: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !last_o && !init_i) |=> ptr_q == $past(ptr_q) - 1'b1);
    // R3: the first trial of a conversion starts from an empty register
    a_r3_msb_first: assert property (@(posedge clk) disable iff (!rst_n)
        init_i |=> (sar_q == '0 && ptr_q == TOP_PTR));
endmodule

// File: rtl/sar_input_map.sv
module sar_input_map
    import sar_ctrl_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  load_i,
    input  logic                  se_i,
    input  logic [SAR_CH_W-1:0]   chan_i,
    output logic [SAR_NUM_IN-1:0] pos_sel_o,
    output logic [SAR_NUM_IN:0]   neg_sel_o
);
    logic                se_q;
    logic [SAR_CH_W-1:0] chan_q;
    logic                valid_q;
    logic [SAR_CH_W-1:0] pos_idx;
    logic [SAR_CH_W-1:0] neg_idx;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            se_q    <= 1'b0;
            chan_q  <= '0;
            valid_q <= 1'b0;
        end else if (load_i) begin
            se_q    <= se_i;
            chan_q  <= chan_i;
            valid_q <= 1'b1;
        end
    end

    // Pair index in the low code bits, polarity/odd half in the top bit
    assign pos_idx = {chan_q[SAR_CH_W-2:0], chan_q[SAR_CH_W-1]};
    assign neg_idx = {chan_q[SAR_CH_W-2:0], ~chan_q[SAR_CH_W-1]};

    for (genvar g = 0; g < SAR_NUM_IN; g++) begin : g_sel
        assign pos_sel_o[g] = valid_q && (pos_idx == SAR_CH_W'(g));
        assign neg_sel_o[g] = valid_q && !se_q && (neg_idx == SAR_CH_W'(g));
    end
    assign neg_sel_o[SAR_NUM_IN] = valid_q && se_q;

    // R4, R5: at most one input on each side of the comparator
    a_r4_pos_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(pos_sel_o));
    a_r5_neg_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(neg_sel_o) && ($countones(neg_sel_o) == $countones(pos_sel_o)));
endmodule

// File: rtl/sar_power_ctl.sv
module sar_power_ctl (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       active_i,
    input  logic       latch_i,
    input  logic [1:0] pwr_i,
    output logic       clk_en_o,
    output logic       ref_en_o,
    output logic       core_en_o
);
    logic [1:0] pwr_q;

    always_ff @(posedge clk) begin
        if (!rst_n)       pwr_q <= 2'b00;
        else if (latch_i) pwr_q <= pwr_i;
    end

    assign clk_en_o  = active_i;
    assign ref_en_o  = active_i | pwr_q[1];
    assign core_en_o = active_i | pwr_q[0];
endmodule

// File: rtl/sar_conv_ctrl.sv
module sar_conv_ctrl
    import sar_ctrl_pkg::*;
#(
    parameter int RES_BITS = 12
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start_i,
    input  logic                  se_i,
    input  logic [SAR_CH_W-1:0]   chan_i,
    input  logic [1:0]            pwr_i,
    input  logic                  cmp_i,
    output logic [RES_BITS-1:0]   dac_code_o,
    output logic [SAR_NUM_IN-1:0] pos_sel_o,
    output logic [SAR_NUM_IN:0]   neg_sel_o,
    output logic                  clk_en_o,
    output logic                  ref_en_o,
    output logic                  core_en_o,
    output logic                  busy_o,
    output logic                  done_o,
    output logic [RES_BITS-1:0]   result_o
);
    sar_state_t          state;
    logic                load, step, finish, last_bit;
    logic [RES_BITS-1:0] code_next;
    logic [RES_BITS-1:0] result_q;

    sar_seq_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .last_bit_i (last_bit),
        .state_o    (state),
        .load_o     (load),
        .step_o     (step),
        .finish_o   (finish)
    );

    sar_search_reg #(.RES_BITS(RES_BITS)) u_search (
        .clk         (clk),
        .rst_n       (rst_n),
        .init_i      (load),
        .step_i      (step),
        .cmp_i       (cmp_i),
        .trial_o     (dac_code_o),
        .code_next_o (code_next),
        .last_o      (last_bit)
    );

    sar_input_map u_map (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (load),
        .se_i      (se_i),
        .chan_i    (chan_i),
        .pos_sel_o (pos_sel_o),
        .neg_sel_o (neg_sel_o)
    );

    sar_power_ctl u_pwr (
        .clk       (clk),
        .rst_n     (rst_n),
        .active_i  (state != ST_IDLE),
        .latch_i   (finish),
        .pwr_i     (pwr_i),
        .clk_en_o  (clk_en_o),
        .ref_en_o  (ref_en_o),
        .core_en_o (core_en_o)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)      result_q <= '0;
        else if (finish) result_q <= code_next;
    end

    assign result_o = result_q;
    assign busy_o   = (state == ST_SAMPLE) || (state == ST_CONVERT);
    assign done_o   = (state == ST_DONE);

    // R2: strobe is one cycle wide and follows the end of busy
    a_r2_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    a_r2_busy_to_done: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> done_o);
    // R6: everything powered while a conversion is active
    a_r6_powered_active: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o || done_o) |-> (clk_en_o && ref_en_o && core_en_o));
    // R9: held result moves only together with the strobe
    a_r9_result_held: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> $stable(result_o));
    // R8: a start outside idle leaves the selects alone
    a_r8_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && (busy_o || done_o)) |=> ($stable(pos_sel_o) && $stable(neg_sel_o)));
endmodule

// File: tb/tb_sar_conv_ctrl.sv
`timescale 1ns/1ps
module tb_sar_conv_ctrl;
    localparam int BITS = 12;
    localparam int LAT  = BITS + 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        se_i = 1'b0;
    logic [2:0]  chan_i = 3'd0;
    logic [1:0]  pwr_i = 2'd0;
    logic        cmp_i;
    logic [11:0] dac_code_o;
    logic [7:0]  pos_sel_o;
    logic [8:0]  neg_sel_o;
    logic        clk_en_o, ref_en_o, core_en_o, busy_o, done_o;
    logic [11:0] result_o;

    int vin [0:7];
    int vcom;
    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    sar_conv_ctrl dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .se_i(se_i),
        .chan_i(chan_i), .pwr_i(pwr_i), .cmp_i(cmp_i),
        .dac_code_o(dac_code_o), .pos_sel_o(pos_sel_o), .neg_sel_o(neg_sel_o),
        .clk_en_o(clk_en_o), .ref_en_o(ref_en_o), .core_en_o(core_en_o),
        .busy_o(busy_o), .done_o(done_o), .result_o(result_o)
    );

    // Ideal threshold comparator driven from the selected inputs
    always_comb begin
        int vp, vn;
        bit hp, hn;
        vp = 0; vn = 0; hp = 0; hn = 0;
        for (int i = 0; i < 8; i++) if (pos_sel_o[i]) begin vp = vin[i]; hp = 1; end
        for (int i = 0; i < 8; i++) if (neg_sel_o[i]) begin vn = vin[i]; hn = 1; end
        if (neg_sel_o[8]) begin vn = vcom; hn = 1; end
        cmp_i = hp && hn && ((vp - vn) >= int'(dac_code_o));
    end

    function automatic int exp_pos(bit se, int ch);
        if (se) return (ch < 4) ? 2 * ch : 2 * (ch - 4) + 1;
        return (ch < 4) ? 2 * ch : 2 * (ch - 4) + 1;
    endfunction

    function automatic int exp_neg(bit se, int ch);
        if (se) return 8;
        return (ch < 4) ? 2 * ch + 1 : 2 * (ch - 4);
    endfunction

    function automatic int exp_code(bit se, int ch);
        int d, vn;
        vn = se ? vcom : vin[exp_neg(se, ch)];
        d = vin[exp_pos(se, ch)] - vn;
        if (d < 0) d = 0;
        if (d > 4095) d = 4095;
        return d;
    endfunction

    task automatic chk(bit ok, string tag, int act, int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    // One conversion; optional stray start while busy
    task automatic run_conv(bit se, int ch, logic [1:0] pw, bit stray);
        int cnt;
        int ecode;
        logic [11:0] held;
        @(negedge clk);
        se_i = se; chan_i = 3'(ch); pwr_i = pw; start_i = 1'b1;
        ecode = exp_code(se, ch);
        @(negedge clk);
        start_i = 1'b0;
        cnt = 1;
        chk(busy_o && clk_en_o && ref_en_o && core_en_o, "R6 enables while busy",
            {busy_o, clk_en_o, ref_en_o, core_en_o}, 15);
        while (!done_o && cnt < 30) begin
            @(negedge clk);
            cnt++;
            if (cnt == 2) chk(dac_code_o == 12'h800, "R3 first trial", dac_code_o, 12'h800);
            if (stray && cnt == 5) begin
                start_i = 1'b1; se_i = ~se; chan_i = 3'(ch) ^ 3'd5;
            end
            if (stray && cnt == 6) start_i = 1'b0;
        end
        chk(cnt == LAT, stray ? "R8 latency with stray start" : "R2 start-to-done latency", cnt, LAT);
        chk(!busy_o, "R2 busy low at done", busy_o, 0);
        chk(result_o == 12'(ecode), "R3 converted code", result_o, ecode);
        chk(pos_sel_o == 8'(1 << exp_pos(se, ch)), se ? "R4 positive select" : "R5 positive select",
            pos_sel_o, 1 << exp_pos(se, ch));
        chk(neg_sel_o == 9'(1 << exp_neg(se, ch)), se ? "R4 negative select" : "R5 negative select",
            neg_sel_o, 1 << exp_neg(se, ch));
        held = result_o;
        @(negedge clk);
        chk(!done_o, "R2 done one cycle", done_o, 0);
        chk(!clk_en_o && ref_en_o == pw[1] && core_en_o == pw[0], "R7 power after done",
            {clk_en_o, ref_en_o, core_en_o}, {1'b0, pw});
        chk(result_o == held, "R9 result held", result_o, held);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [11:0] keep;
        logic [7:0]  kp;
        logic [8:0]  kn;
        void'($urandom(32'h5A17));
        for (int i = 0; i < 8; i++) vin[i] = 100 * (i + 1);
        vcom = 0;
        repeat (3) @(negedge clk);
        chk(!busy_o && !done_o && !clk_en_o && !ref_en_o && !core_en_o, "R1 reset flags",
            {busy_o, done_o, clk_en_o, ref_en_o, core_en_o}, 0);
        chk(result_o == 0 && pos_sel_o == 0 && neg_sel_o == 0, "R1 reset result/selects",
            result_o, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R4 and R5: every code in both modes
        for (int c = 0; c < 8; c++) begin
            for (int i = 0; i < 8; i++) vin[i] = 300 * i + 17 * c + 5;
            vcom = 3;
            run_conv(1'b1, c, 2'b11, 1'b0);
            run_conv(1'b0, c, 2'(c), 1'b0);
        end

        // R3 boundaries: full scale, zero, negative difference, mid-scale neighbours
        vcom = 0; vin[0] = 4095; run_conv(1'b1, 0, 2'b00, 1'b0);
        vin[2] = 0;              run_conv(1'b1, 1, 2'b01, 1'b0);
        vin[4] = 100; vin[5] = 900; run_conv(1'b0, 2, 2'b10, 1'b0);
        vin[6] = 2048; vin[7] = 0;  run_conv(1'b0, 3, 2'b00, 1'b0);
        vin[6] = 2047;              run_conv(1'b0, 3, 2'b11, 1'b0);

        // R8: stray start during conversion
        vin[3] = 1234; vcom = 200;
        run_conv(1'b1, 5, 2'b10, 1'b1);

        // R9, R10: idle with changing inputs keeps result and selects
        keep = result_o; kp = pos_sel_o; kn = neg_sel_o;
        for (int i = 0; i < 8; i++) vin[i] = 4000 - i;
        vcom = 0;
        repeat (6) @(negedge clk);
        chk(result_o == keep, "R9 result stable in idle", result_o, keep);
        chk(pos_sel_o == kp && neg_sel_o == kn, "R10 selects kept in idle", pos_sel_o, kp);

        // Random conversions
        for (int k = 0; k < 40; k++) begin
            for (int i = 0; i < 8; i++) vin[i] = int'($urandom_range(0, 4095));
            vcom = int'($urandom_range(0, 300));
            run_conv(1'($urandom_range(0, 1)), int'($urandom_range(0, 7)),
                     2'($urandom_range(0, 3)), (k % 7) == 3);
        end

        finish_run();
    end
endmodule